// File: doc/BRIEF.md
# Secure and Privileged Register Access Filter

This block sits between a register bus and a bank of functional control registers. It checks every access against its security and privilege attributes. Each request carries a secure flag and a privileged flag. The block owns two attribute registers. The item security register marks groups of bits as secure. The privilege register holds one privilege bit for secure bits and another for non-secure bits. The filter uses these to build a per-bit allow mask. That mask gates the bit write enables sent to the functional bank and zeroes the read data that comes back. A denied access still completes normally. A write is dropped without a trace, and a read returns zero bits.

A global security enable input switches the security model on and off. While it is low, the item security register reads as zero and ignores writes, and every functional bit is treated as non-secure. A parameter names some functional registers as status registers. The non-secure bits of these registers stay readable by unprivileged code. The functional registers themselves live outside the block. The filter drives their index, write data and bit write enables, and it receives their read data combinationally.

Top module: `sec_priv_access_filter`

## Requirements
- R1: After reset, the item security register and both privilege bits are 0. `rsp_valid` is low. Every functional bit accepts unprivileged non-secure reads and writes.
- R2: Every request gets `rsp_valid` exactly one cycle later, whether it was allowed or denied. A write response carries zero data.
- R3: Word address 0 is the item security register, and word address 1 is the privilege register. Functional register k sits at word address k+2. Item security bit i covers bits [i*FW +: FW] of every functional register, where FW = DW/ITEMS.
- R4: When security is enabled, a non-secure access to a bit marked secure is refused. Its write enable stays low and its read data is 0.
- R5: While `sec_en` is 0, the item security register reads as 0 and ignores writes, and every functional bit is non-secure.
- R6: While `sec_en` is 1, any access may read the item security register. Only a secure access can write it, and that access must also be privileged when the secure-privilege bit is set.
- R7: In the privilege register, bit 0 is secure-privilege and bit 1 is non-secure-privilege. Any access may read this register. Bit 0 changes only on a secure privileged write. Bit 1 changes on any privileged write. Unprivileged writes change neither bit.
- R8: While the secure-privilege bit is set, secure functional bits can be read and written only by privileged secure accesses.
- R9: While the non-secure-privilege bit is set, non-secure functional bits can be read and written only by privileged accesses.
- R10: In functional registers flagged by OPEN_MASK, unprivileged accesses can still read the non-secure bits when the non-secure-privilege bit is set. Writes to these bits stay privilege-gated.
- R11: A bit's write enable is its byte strobe ANDed with its allow bit. This also applies to the attribute registers.
- R12: A word address beyond the last functional register reads 0. A write to such an address raises no functional write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_en | input | 1 | Global security enable |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_strb | input | DW/8 | Byte strobes |
| req_secure | input | 1 | Access is secure |
| req_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Response, one cycle after request |
| rsp_rdata | output | DW | Masked read data |
| fn_addr | output | IW | Functional register index |
| fn_we | output | 1 | Functional write cycle |
| fn_wbe | output | DW | Per-bit functional write enable |
| fn_wdata | output | DW | Functional write data |
| fn_rdata | input | DW | Functional read data from the bank |

## Verification
The main sweep covers every combination of the global enable, all 16 item security codes, all four privilege codes, both functional registers, both access flags, read or write, and every strobe pattern. It preloads a known pattern into the bank each time. The result tells apart the secure and non-secure masking on each bit group, the status-register read exception, and the strobe gating. Separate sweeps write every value into the privilege register from every prior state and under every flag combination, and they exercise the item security register with the enable on and off. These sweeps tell apart the rule that the secure bit needs a secure access from the rule that only needs privilege. Out-of-range addresses and the reset state are checked on their own.

// File: rtl/sec_priv_access_filter.sv
module sec_priv_access_filter #(
  parameter int DW = 32,
  parameter int ITEMS = 8,
  parameter int NREG = 4,
  parameter int AW = 8,
  parameter logic [NREG-1:0] OPEN_MASK = 4'b1000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sec_en,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [AW-1:0]              req_addr,
  input  logic [DW-1:0]              req_wdata,
  input  logic [DW/8-1:0]            req_strb,
  input  logic                       req_secure,
  input  logic                       req_priv,
  output logic                       rsp_valid,
  output logic [DW-1:0]              rsp_rdata,
  output logic [((NREG>1)?$clog2(NREG):1)-1:0] fn_addr,
  output logic                       fn_we,
  output logic [DW-1:0]              fn_wbe,
  output logic [DW-1:0]              fn_wdata,
  input  logic [DW-1:0]              fn_rdata
);
  localparam int FW = DW / ITEMS;
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [ITEMS-1:0] item_sec;
  logic             spriv, nspriv;
  logic [DW-1:0]    sec_bits, strb_bits, allow, rd_mux;
  logic             sel_sec, sel_priv, sel_fn, open_hit, ok_sec, ok_ns, sec_wr_ok;

  for (genvar b = 0; b < DW; b++) begin : g_bits
    assign sec_bits[b]  = sec_en & item_sec[b / FW];
    assign strb_bits[b] = req_strb[b / 8];
  end

  assign sel_sec  = req_addr == AW'(0);
  assign sel_priv = req_addr == AW'(1);
  assign sel_fn   = (req_addr >= AW'(2)) && (req_addr < AW'(NREG + 2));
  assign fn_addr  = IW'(req_addr - AW'(2));
  assign open_hit = sel_fn & OPEN_MASK[fn_addr];

  assign ok_sec = req_secure & (~spriv | req_priv);
  assign ok_ns  = ~nspriv | req_priv | (~req_write & open_hit);
  assign allow  = (sec_bits & {DW{ok_sec}}) | (~sec_bits & {DW{ok_ns}});

  assign fn_we    = req_valid & req_write & sel_fn;
  assign fn_wbe   = allow & strb_bits & {DW{fn_we}};
  assign fn_wdata = req_wdata;

  assign sec_wr_ok = sec_en & req_secure & (~spriv | req_priv);

  always_comb begin
    rd_mux = '0;
    if (sel_sec)       rd_mux = sec_en ? DW'(item_sec) : '0;
    else if (sel_priv) rd_mux = DW'({nspriv, spriv});
    else if (sel_fn)   rd_mux = fn_rdata & allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      item_sec  <= '0;
      spriv     <= 1'b0;
      nspriv    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid & ~req_write) ? rd_mux : '0;
      if (req_valid & req_write & sel_sec & sec_wr_ok)
        item_sec <= (item_sec & ~strb_bits[ITEMS-1:0]) | (req_wdata[ITEMS-1:0] & strb_bits[ITEMS-1:0]);
      if (req_valid & req_write & sel_priv & req_priv & req_strb[0]) begin
        nspriv <= req_wdata[1];
        if (req_secure) spriv <= req_wdata[0];
      end
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NS_NO_SEC_WBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & ~req_secure) |-> ((fn_wbe & sec_bits) == '0)); // R4
  AST_SECCFG_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & ~req_write & sel_sec & ~sec_en) |=> (rsp_rdata == '0)); // R5
  AST_SECCFG_NS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & req_write & sel_sec & ~req_secure) |=> $stable(item_sec)); // R6
  AST_SPRIV_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & req_write & sel_priv & ~(req_secure & req_priv)) |=> $stable(spriv)); // R7
  AST_NSPRIV_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & req_write & sel_priv & ~req_priv) |=> $stable(nspriv)); // R7
  AST_WBE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_wbe & ~strb_bits) == '0); // R11
  AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & (req_addr >= AW'(NREG + 2))) |-> !fn_we); // R12
endmodule

// File: tb/sec_priv_access_filter_tb.sv
module sec_priv_access_filter_tb;
  localparam int DW = 16, ITEMS = 4, NREG = 2, AW = 3;

  logic clk = 0, rst_n = 0, sec_en = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0, req_priv = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_strb = '0;
  logic rsp_valid, fn_we;
  logic [DW-1:0] rsp_rdata, fn_wbe, fn_wdata, fn_rdata;
  logic [0:0] fn_addr;
  logic [DW-1:0] bank [NREG];
  logic pre_en = 0;
  logic [0:0] pre_idx = '0;
  logic [DW-1:0] pre_val = '0;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  sec_priv_access_filter #(.DW(DW), .ITEMS(ITEMS), .NREG(NREG), .AW(AW), .OPEN_MASK(2'b10)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb), .req_secure(req_secure),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fn_addr(fn_addr),
    .fn_we(fn_we), .fn_wbe(fn_wbe), .fn_wdata(fn_wdata), .fn_rdata(fn_rdata));

  assign fn_rdata = bank[fn_addr];

  always_ff @(posedge clk) begin
    if (pre_en) bank[pre_idx] <= pre_val;
    else if (fn_we) bank[fn_addr] <= (bank[fn_addr] & ~fn_wbe) | (fn_wdata & fn_wbe);
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [1:0] st, input logic s, input logic p);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_strb = st;
    req_secure = s; req_priv = p;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic preload(input int idx, input logic [DW-1:0] v);
    @(negedge clk);
    pre_en = 1; pre_idx = idx[0:0]; pre_val = v;
    @(negedge clk);
    pre_en = 0;
  endtask

  task automatic set_cfg(input logic sen, input logic [3:0] sc, input logic [1:0] pc);
    sec_en = 1;
    acc(1, 1, 16'h0, 2'b11, 1, 1);
    acc(1, 0, DW'(sc), 2'b11, 1, 1);
    acc(1, 1, DW'(pc), 2'b11, 1, 1);
    sec_en = sen;
  endtask

  function automatic logic [DW-1:0] expand(input logic [3:0] s);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = s[b / 4];
    return r;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid reset", DW'(rsp_valid), 16'h0);
    rst_n = 1;
    sec_en = 1;
    acc(0, 0, 0, 0, 0, 0);
    chk("R1 seccfg reset", rsp_rdata, 16'h0);
    chk("R2 rsp_valid", DW'(rsp_valid), 16'h1);
    acc(0, 1, 0, 0, 0, 0);
    chk("R1 privcfg reset", rsp_rdata, 16'h0);
    preload(0, 16'h0000);
    acc(1, 2, 16'hBEEF, 2'b11, 0, 0);
    chk("R1 unpriv write after reset", bank[0], 16'hBEEF);
    chk("R2 write rsp zero", rsp_rdata, 16'h0);

    // R4 R5 R8 R9 R10 R11 R3: full sweep
    for (int sen = 0; sen < 2; sen++)
      for (int sc = 0; sc < 16; sc++)
        for (int pc = 0; pc < 4; pc++) begin
          set_cfg(sen[0], sc[3:0], pc[1:0]);
          for (int r = 0; r < 2; r++)
            for (int s = 0; s < 2; s++)
              for (int p = 0; p < 2; p++)
                for (int wr = 0; wr < 2; wr++)
                  for (int st = 0; st < (wr ? 4 : 1); st++) begin
                    logic [DW-1:0] pat, wd, smask, allow, m;
                    logic oks, okn;
                    pat = 16'hA5C3 ^ DW'(sc * 16'h1111) ^ DW'(r * 16'h0F0F);
                    wd = ~pat ^ DW'(pc);
                    smask = sen ? expand(sc[3:0]) : 16'h0;
                    oks = s[0] & (!pc[0] | p[0]);
                    okn = !pc[1] | p[0] | (!wr[0] & (r == 1));
                    allow = (smask & {DW{oks}}) | (~smask & {DW{okn}});
                    preload(r, pat);
                    if (wr) begin
                      m = allow & {{8{st[1]}}, {8{st[0]}}};
                      acc(1, AW'(r + 2), wd, st[1:0], s[0], p[0]);
                      chk("R4/R8/R9/R11 write", bank[r], (pat & ~m) | (wd & m));
                    end else begin
                      acc(0, AW'(r + 2), 0, 0, s[0], p[0]);
                      chk("R3/R4/R5/R8/R9/R10 read", rsp_rdata, pat & allow);
                    end
                  end
        end

    // R7 privilege register sweep
    for (int st0 = 0; st0 < 4; st0++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++)
          for (int w = 0; w < 4; w++) begin
            logic [1:0] e;
            set_cfg(1, 0, st0[1:0]);
            acc(1, 1, DW'(w), 2'b01, s[0], p[0]);
            e[0] = (s[0] & p[0]) ? w[0] : st0[0];
            e[1] = p[0] ? w[1] : st0[1];
            acc(0, 1, 0, 0, 0, 0);
            chk("R7 privcfg write rules", rsp_rdata, DW'(e));
          end

    // R5 R6 item security register
    for (int sen = 0; sen < 2; sen++)
      for (int sp = 0; sp < 2; sp++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 2; p++) begin
            logic [3:0] e;
            set_cfg(1, 4'h5, {1'b0, sp[0]});
            sec_en = sen[0];
            acc(1, 0, 16'h000A, 2'b01, s[0], p[0]);
            e = (sen[0] & s[0] & (!sp[0] | p[0])) ? 4'hA : 4'h5;
            acc(0, 0, 0, 0, 0, 0);
            chk("R5/R6 seccfg read", rsp_rdata, sen ? DW'(e) : 16'h0);
            sec_en = 1;
            acc(0, 0, 0, 0, 0, 0);
            chk("R5/R6 seccfg held", rsp_rdata, DW'(e));
          end
    set_cfg(1, 4'h5, 2'b00);
    acc(1, 0, 16'h000A, 2'b10, 1, 1);
    acc(0, 0, 0, 0, 0, 0);
    chk("R11 seccfg strobe", rsp_rdata, 16'h0005);

    // R12 out of range
    set_cfg(0, 0, 0);
    preload(0, 16'h1234);
    preload(1, 16'h5678);
    for (int a = 4; a < 8; a++) begin
      acc(1, AW'(a), 16'hFFFF, 2'b11, 1, 1);
      chk("R12 oor write reg0", bank[0], 16'h1234);
      chk("R12 oor write reg1", bank[1], 16'h5678);
      acc(0, AW'(a), 0, 0, 1, 1);
      chk("R12 oor read", rsp_rdata, 16'h0);
      chk("R2 oor rsp_valid", DW'(rsp_valid), 16'h1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule